// File: doc/BRIEF.md
# Implicit-Operand Function-Coded ALU

This block is the arithmetic and logic unit of a small 16-bit datapath in which ALU instructions carry no register fields. Two dedicated source registers and one dedicated destination register surround the unit. Each of them can be loaded from the internal data bus by a register move. When the control unit issues an ALU instruction, it raises `alu_go` and presents the instruction's 12 low bits on `func_code`. At that clock edge the unit computes the selected function of the two held sources and writes it to the destination register.

The function code space is sparse. Only the upper nibble selects among thirteen defined functions, and the lower eight bits must be zero. Any other code is treated as undefined and changes nothing. A zero flag records whether the last defined ALU result was zero, so that a later conditional move can test it. A carry flag records the carry or borrow of the last add or subtract, and feeds the carry-chained add and subtract variants. Every function completes in the single execute cycle of its instruction.

Top module: `fc_alu`

## Requirements
- R1: After reset the two source registers, the destination register, the zero flag and the carry flag are all zero.
- R2: When `ld_src1`, `ld_src2` or `ld_dst` is high at a clock edge, that register takes the value of `bus_data` at that edge.
- R3: A defined ALU instruction (`alu_go` high) writes its result to the destination register at the same edge, using the source values held before that edge. If `ld_dst` is high in the same cycle, the ALU result wins.
- R4: Code 0x100 writes src1+src2 and code 0x200 writes src1-src2, both modulo 2^16. The carry flag becomes the carry out for add, and the borrow (src1 < src2) for subtract.
- R5: Code 0x300 writes src1+src2+carry and code 0x000 writes src1-src2-carry. Each one updates the carry flag with its own carry out or borrow.
- R6: Code 0x400 writes ~src1, 0x500 writes src1 AND src2, 0x600 writes src1 OR src2, and 0xA00 writes src1 unchanged.
- R7: Code 0x700 writes src1+1, 0xB00 writes src1-1 and 0x800 writes the two's-complement negation of src1, all modulo 2^16. None of them changes the carry flag.
- R8: Code 0x900 writes src1[7:0] in bits [15:8] and src2[7:0] in bits [7:0].
- R9: Code 0xC00 writes the 16-bit unsigned product src1[7:0] * src2[7:0].
- R10: After every defined ALU instruction, the zero flag is 1 exactly when the written result is zero.
- R11: An ALU instruction with any other code leaves the destination register, the zero flag and the carry flag unchanged. This covers codes with nonzero bits [7:0] and upper nibbles 0xD to 0xF.
- R12: In any cycle without `alu_go`, which includes a bus load of the destination register, the zero and carry flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 16 | Internal bus value for register loads |
| ld_src1 | input | 1 | Load source register 1 from the bus |
| ld_src2 | input | 1 | Load source register 2 from the bus |
| ld_dst | input | 1 | Load destination register from the bus |
| alu_go | input | 1 | Execute an ALU instruction this cycle |
| func_code | input | 12 | Function code, the instruction's low 12 bits |
| src1_q | output | 16 | Source register 1 |
| src2_q | output | 16 | Source register 2 |
| dst_q | output | 16 | Destination register |
| zero_q | output | 1 | Zero status of the last defined ALU result |
| carry_q | output | 1 | Carry/borrow of the last add or subtract |

## Verification
The bench builds the block with its default parameters: a 16-bit datapath, a 12-bit function code whose top nibble selects the operation, and the byte multiplier present. Because the width is 16 bits, random operands land on carry out, borrow and all-zero results often, and directed cases pin down the wrap points 0xFFFF+1 and 0-1. Having the multiplier present makes code 0xC00 reachable, while codes 0xD00 and above, along with codes whose low byte is nonzero, exercise the undefined path.

// File: rtl/fc_alu_pkg.sv
package fc_alu_pkg;

    typedef enum logic [3:0] {
        FN_SUBC  = 4'h0,
        FN_ADD   = 4'h1,
        FN_SUB   = 4'h2,
        FN_ADDC  = 4'h3,
        FN_INV   = 4'h4,
        FN_AND   = 4'h5,
        FN_OR    = 4'h6,
        FN_INC   = 4'h7,
        FN_NEG   = 4'h8,
        FN_CAT   = 4'h9,
        FN_IDENT = 4'hA,
        FN_DEC   = 4'hB,
        FN_MUL   = 4'hC,
        FN_NONE  = 4'hF
    } fn_e;

    function automatic logic fn_is_chain(input fn_e f);
        return (f == FN_ADD) || (f == FN_SUB) || (f == FN_ADDC) || (f == FN_SUBC);
    endfunction

endpackage

// File: rtl/fc_alu_decode.sv
module fc_alu_decode
    import fc_alu_pkg::*;
#(
    parameter int FUNC_W  = 12,
    parameter int SEL_LSB = 8,
    parameter bit HAS_MUL = 1'b1
) (
    input  logic [FUNC_W-1:0] code,
    output fn_e               fn,
    output logic              valid
);
    localparam int SEL_W = FUNC_W - SEL_LSB;

    logic [SEL_W-1:0]   sel;
    logic [SEL_LSB-1:0] pad;

    assign sel = code[FUNC_W-1:SEL_LSB];
    assign pad = code[SEL_LSB-1:0];

    always_comb begin
        fn    = FN_NONE;
        valid = 1'b0;
        if (pad == '0) begin
            valid = 1'b1;
            case (sel)
                SEL_W'(4'h0): fn = FN_SUBC;
                SEL_W'(4'h1): fn = FN_ADD;
                SEL_W'(4'h2): fn = FN_SUB;
                SEL_W'(4'h3): fn = FN_ADDC;
                SEL_W'(4'h4): fn = FN_INV;
                SEL_W'(4'h5): fn = FN_AND;
                SEL_W'(4'h6): fn = FN_OR;
                SEL_W'(4'h7): fn = FN_INC;
                SEL_W'(4'h8): fn = FN_NEG;
                SEL_W'(4'h9): fn = FN_CAT;
                SEL_W'(4'hA): fn = FN_IDENT;
                SEL_W'(4'hB): fn = FN_DEC;
                SEL_W'(4'hC): begin
                    fn    = HAS_MUL ? FN_MUL : FN_NONE;
                    valid = HAS_MUL;
                end
                default: begin
                    fn    = FN_NONE;
                    valid = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/fc_alu_chain.sv
module fc_alu_chain
    import fc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  fn_e               fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic [EXT_W-1:0] ext_c;
    logic [EXT_W-1:0] ext_r;
    logic             use_cin;
    logic             is_sub;

    assign ext_a   = {1'b0, a};
    assign ext_b   = {1'b0, b};
    assign use_cin = (fn == FN_ADDC) || (fn == FN_SUBC);
    assign is_sub  = (fn == FN_SUB) || (fn == FN_SUBC);
    assign ext_c   = {{DATA_W{1'b0}}, (use_cin & cin)};

    always_comb begin
        if (is_sub) ext_r = ext_a - ext_b - ext_c;
        else        ext_r = ext_a + ext_b + ext_c;
    end

    assign sum  = ext_r[DATA_W-1:0];
    assign cout = ext_r[DATA_W];

endmodule

// File: rtl/fc_alu_misc.sv
module fc_alu_misc
    import fc_alu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit HAS_MUL = 1'b1
) (
    input  fn_e               fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] prod;
    logic [DATA_W-1:0] one;

    assign one = {{(DATA_W-1){1'b0}}, 1'b1};

    generate
        if (HAS_MUL) begin : g_mul
            logic [HALF_W-1:0] ma;
            logic [HALF_W-1:0] mb;
            assign ma   = a[HALF_W-1:0];
            assign mb   = b[HALF_W-1:0];
            assign prod = DATA_W'(ma) * DATA_W'(mb);
        end else begin : g_no_mul
            assign prod = '0;
        end
    endgenerate

    always_comb begin
        case (fn)
            FN_INV:   res = ~a;
            FN_AND:   res = a & b;
            FN_OR:    res = a | b;
            FN_INC:   res = a + one;
            FN_DEC:   res = a - one;
            FN_NEG:   res = (~a) + one;
            FN_CAT:   res = {a[HALF_W-1:0], b[HALF_W-1:0]};
            FN_IDENT: res = a;
            FN_MUL:   res = prod;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/fc_alu.sv
module fc_alu
    import fc_alu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int FUNC_W  = 12,
    parameter int SEL_LSB = 8,
    parameter bit HAS_MUL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              ld_src1,
    input  logic              ld_src2,
    input  logic              ld_dst,
    input  logic              alu_go,
    input  logic [FUNC_W-1:0] func_code,
    output logic [DATA_W-1:0] src1_q,
    output logic [DATA_W-1:0] src2_q,
    output logic [DATA_W-1:0] dst_q,
    output logic              zero_q,
    output logic              carry_q
);

    typedef struct packed {
        logic [DATA_W-1:0] src1;
        logic [DATA_W-1:0] src2;
        logic [DATA_W-1:0] dst;
        logic              zero;
        logic              carry;
    } alu_state_t;

    alu_state_t st_d, st_q;

    fn_e               fn;
    logic              fn_valid;
    logic [DATA_W-1:0] chain_res;
    logic              chain_cout;
    logic [DATA_W-1:0] misc_res;
    logic [DATA_W-1:0] alu_res;
    logic              chain_sel;

    fc_alu_decode #(
        .FUNC_W  (FUNC_W),
        .SEL_LSB (SEL_LSB),
        .HAS_MUL (HAS_MUL)
    ) u_decode (
        .code  (func_code),
        .fn    (fn),
        .valid (fn_valid)
    );

    fc_alu_chain #(
        .DATA_W (DATA_W)
    ) u_chain (
        .fn   (fn),
        .a    (st_q.src1),
        .b    (st_q.src2),
        .cin  (st_q.carry),
        .sum  (chain_res),
        .cout (chain_cout)
    );

    fc_alu_misc #(
        .DATA_W  (DATA_W),
        .HAS_MUL (HAS_MUL)
    ) u_misc (
        .fn  (fn),
        .a   (st_q.src1),
        .b   (st_q.src2),
        .res (misc_res)
    );

    assign chain_sel = fn_is_chain(fn);
    assign alu_res   = chain_sel ? chain_res : misc_res;

    always_comb begin
        st_d = st_q;
        if (ld_src1) st_d.src1 = bus_data;
        if (ld_src2) st_d.src2 = bus_data;
        if (ld_dst)  st_d.dst  = bus_data;
        if (alu_go && fn_valid) begin
            st_d.dst  = alu_res;
            st_d.zero = (alu_res == '0);
            if (chain_sel) st_d.carry = chain_cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src1_q  = st_q.src1;
    assign src2_q  = st_q.src2;
    assign dst_q   = st_q.dst;
    assign zero_q  = st_q.zero;
    assign carry_q = st_q.carry;

    p_load_src1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_src1 |=> src1_q == $past(bus_data));

    p_zero_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_go && fn_valid) |=> zero_q == (dst_q == '0));

    p_undef_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_go && !fn_valid && !ld_dst) |=> ($stable(dst_q) && $stable(zero_q) && $stable(carry_q)));

    p_idle_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !alu_go |=> ($stable(zero_q) && $stable(carry_q)));

    p_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_go && fn == FN_INC) |=> (dst_q == $past(src1_q) + DATA_W'(1) && $stable(carry_q)));

endmodule

// File: tb/fc_alu_bench.sv
module fc_alu_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  bus_data = '0;
    logic          ld_src1 = 1'b0, ld_src2 = 1'b0, ld_dst = 1'b0, alu_go = 1'b0;
    logic [11:0]   func_code = '0;
    logic [W-1:0]  src1_q, src2_q, dst_q;
    logic          zero_q, carry_q;

    int n_checks = 0;
    int n_fail   = 0;

    logic [W-1:0] m_s1 = '0, m_s2 = '0, m_dst = '0;
    logic         m_z = 1'b0, m_c = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fc_alu u_fc_alu (
        .clk, .rst_n, .bus_data, .ld_src1, .ld_src2, .ld_dst, .alu_go,
        .func_code, .src1_q, .src2_q, .dst_q, .zero_q, .carry_q
    );

    // returns {valid, carry_written, carry_value, result}
    function automatic logic [W+2:0] model(input logic [11:0] code,
                                           input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic c);
        logic [W:0] t;
        if (code[7:0] != 8'h00) return '0;
        case (code[11:8])
            4'h0: begin t = {1'b0,a} - {1'b0,b} - {{W{1'b0}},c}; return {1'b1,1'b1,t[W],t[W-1:0]}; end
            4'h1: begin t = {1'b0,a} + {1'b0,b};                 return {1'b1,1'b1,t[W],t[W-1:0]}; end
            4'h2: begin t = {1'b0,a} - {1'b0,b};                 return {1'b1,1'b1,t[W],t[W-1:0]}; end
            4'h3: begin t = {1'b0,a} + {1'b0,b} + {{W{1'b0}},c}; return {1'b1,1'b1,t[W],t[W-1:0]}; end
            4'h4: return {3'b100, ~a};
            4'h5: return {3'b100, a & b};
            4'h6: return {3'b100, a | b};
            4'h7: return {3'b100, a + 16'd1};
            4'h8: return {3'b100, 16'd0 - a};
            4'h9: return {3'b100, a[7:0], b[7:0]};
            4'hA: return {3'b100, a};
            4'hB: return {3'b100, a - 16'd1};
            4'hC: return {3'b100, 16'(a[7:0]) * 16'(b[7:0])};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] code);
        if (code[7:0] != 8'h00) return "R11";
        case (code[11:8])
            4'h1, 4'h2: return "R4";
            4'h0, 4'h3: return "R5";
            4'h4, 4'h5, 4'h6, 4'hA: return "R6";
            4'h7, 4'h8, 4'hB: return "R7";
            4'h9: return "R8";
            4'hC: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, compare at the next falling edge
    task automatic step(input string tag, input logic l1, input logic l2, input logic ld,
                        input logic [W-1:0] bus, input logic go, input logic [11:0] code);
        logic [W+2:0] r;
        r = model(code, m_s1, m_s2, m_c);
        bus_data = bus; ld_src1 = l1; ld_src2 = l2; ld_dst = ld;
        alu_go = go; func_code = code;
        if (ld) m_dst = bus;
        if (go && r[W+2]) begin
            m_dst = r[W-1:0];
            m_z   = (r[W-1:0] == '0);
            if (r[W+1]) m_c = r[W];
        end
        if (l1) m_s1 = bus;
        if (l2) m_s2 = bus;
        @(posedge clk);
        @(negedge clk);
        ld_src1 = 1'b0; ld_src2 = 1'b0; ld_dst = 1'b0; alu_go = 1'b0;
        check(tag, "src1", src1_q, m_s1);
        check(tag, "src2", src2_q, m_s2);
        check(tag, "dst",  dst_q,  m_dst);
        check(tag, "zero", {15'd0, zero_q},  {15'd0, m_z});
        check(tag, "carry", {15'd0, carry_q}, {15'd0, m_c});
    endtask

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [11:0] code);
        step("R2", 1'b1, 1'b0, 1'b0, a, 1'b0, 12'h000);
        step("R2", 1'b0, 1'b1, 1'b0, b, 1'b0, 12'h000);
        step(tag_of(code), 1'b0, 1'b0, 1'b0, '0, 1'b1, code);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] codes [13];
        void'($urandom(32'd5117));
        for (int i = 0; i < 13; i++) codes[i] = (i == 0) ? 12'h000 : 12'(i << 8);

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "src1", src1_q, '0);
        check("R1", "dst",  dst_q,  '0);
        check("R1", "zero", {15'd0, zero_q}, '0);
        check("R1", "carry", {15'd0, carry_q}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_op(16'hFFFF, 16'h0001, 12'h100);  // R4 wrap to zero, carry out, zero flag (R10)
        run_op(16'h0005, 16'h0007, 12'h200);  // R4 borrow
        run_op(16'h0010, 16'h0003, 12'h000);  // R5 subc uses borrow
        run_op(16'h0001, 16'h0001, 12'h300);  // R5 addc
        run_op(16'h00FF, 16'hAAFF, 12'hC00);  // R9 0xFE01
        run_op(16'h1234, 16'h5678, 12'h900);  // R8 0x3478
        run_op(16'h0000, 16'h0000, 12'hB00);  // R7 0 - 1
        run_op(16'h0000, 16'h0000, 12'h800);  // R7 neg of zero
        run_op(16'h4321, 16'h0000, 12'hD00);  // R11 undefined nibble
        run_op(16'h4321, 16'h0000, 12'h101);  // R11 nonzero low byte
        // R12: bus move into dst does not touch flags
        step("R12", 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 12'h000);
        step("R12", 1'b0, 1'b0, 1'b1, 16'hBEEF, 1'b0, 12'h100);
        // R3: ALU write wins over bus load; sources loaded same cycle are not used yet
        step("R3", 1'b1, 1'b1, 1'b1, 16'h7777, 1'b1, 12'h100);
        step("R3", 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 12'hA00);
        // R11 with simultaneous dst load: load applies, flags hold
        step("R11", 1'b0, 1'b0, 1'b1, 16'h0C0C, 1'b1, 12'hF00);

        // constrained random
        for (int k = 0; k < 600; k++) begin
            logic [11:0] code;
            logic [W-1:0] a, b;
            int pick;
            pick = int'($urandom_range(0, 9));
            if (pick < 8)       code = codes[$urandom_range(0, 12)];
            else if (pick == 8) code = 12'($urandom);
            else                code = {4'($urandom_range(13, 15)), 8'h00};
            a = 16'($urandom);
            b = 16'($urandom);
            if ($urandom_range(0, 7) == 0) b = a;
            if ($urandom_range(0, 7) == 0) a = '0;
            if ($urandom_range(0, 1) == 0) run_op(a, b, code);
            else step(tag_of(code), 1'b0, 1'b0, 1'b0, '0, 1'b1, code);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule